// File: doc/BRIEF.md
# Watermark-Gated Dual-Clock Burst Write Buffer

This block posts burst writes from a slave port running on a write clock to a drain port running on an independent read clock. Each stored word carries a tag that marks the final word of its burst. Two gray-coded counters cross the clock boundary, one counting stored words and one counting finished bursts. The drain side hands a burst onward only after every word of that burst is visible in its own domain. After that, the burst leaves at one word per read cycle.

A high-watermark flag rises whenever fewer than `WM` word slots are free. While no burst is open, the slave refuses the first word of a new burst as long as the flag is up. A burst that was already admitted runs on without regard to the flag. If a burst's word takes the last free slot, that word is stored as the burst's end and a cut pulse is returned with its acknowledge. Any further words count as a new burst and must wait for the watermark to clear. The result is that a full buffer drains in long bursts and does not settle into a stream of short ones.

Top module: `wmfifo_burst`

## Requirements
- R1: After reset the buffer is empty: `wm_high` is 0, `rd_valid` is 0, and the first word of a burst is acknowledged in the same cycle it is offered.
- R2: Words leave the read port in the order they were written. `rd_last` is 1 exactly on the word that was written with `s_last` = 1, or on a word that ended its burst through a cut.
- R3: No word of a burst is presented at the read port until the final word of that burst has been written. `rd_valid` is never 1 unless the synchronized word pointer shows at least one unread word.
- R4: `wm_high` is 1 exactly when the free space, computed from the write pointer and the synchronized read pointer, is below `WM`. With `DEPTH`=64 and `WM`=32 and no reads, it is 0 after 32 stored words and 1 after 33 stored words.
- R5: While no burst is open and `wm_high` is 1, an offered word is not acknowledged.
- R6: Once a burst has been admitted, each of its words is acknowledged in the cycle it is offered whenever the buffer is not full, whatever the value of `wm_high`.
- R7: A word that is accepted into the last free slot and has `s_last` = 0 is acknowledged with `s_cut` = 1. It is stored as a burst end, and the burst is closed. The next offered word is treated as the first word of a new burst.
- R8: No word is acknowledged while the buffer is full.
- R9: The read port transfers one word on each read-clock edge where `rd_valid` and `rd_ready` are both 1. A complete burst is delivered on consecutive cycles while `rd_ready` stays 1. While `rd_ready` is 0, `rd_valid`, `rd_data` and `rd_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| s_stb | input | 1 | Write request for the word on `s_data` |
| s_last | input | 1 | Offered word is the last of its burst |
| s_data | input | DW | Offered write data |
| s_ack | output | 1 | Word taken in this cycle (combinational) |
| s_cut | output | 1 | With `s_ack`: the burst was closed because the buffer filled |
| wm_high | output | 1 | Fewer than `WM` slots are free |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_ready | input | 1 | Downstream accepts a word |
| rd_valid | output | 1 | Word available on `rd_data` |
| rd_last | output | 1 | Presented word ends its burst |
| rd_data | output | DW | Presented read data |

## Verification
`s_ack` and `s_cut` are combinational, so the bench samples them 1 ns after it drives a word and before the edge that commits the word. `wm_high` follows the write pointer at the committing edge, so the bench samples it 1 ns after that edge. A finished burst crosses one source-side gray register and then two read-side flops, so it appears within three to four read cycles. The bench therefore checks that `rd_valid` stays 0 for six read cycles before the final word is written. After the final word, it polls for at most twelve read cycles. The watermark release after a drain crosses the same way in the other direction and is polled with a bounded wait.

// File: rtl/wmf_pkg.sv
package wmf_pkg;

    typedef enum logic {
        ADM_IDLE  = 1'b0,
        ADM_BURST = 1'b1
    } adm_state_t;

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/wmf_gray_cross.sv
// Carries a binary counter across clock domains as gray code: one source
// register, two destination flops, then conversion back to binary.
module wmf_gray_cross #(
    parameter int W = 7
) (
    input  logic         src_clk,
    input  logic         src_rst,
    input  logic [W-1:0] src_bin,
    input  logic         dst_clk,
    input  logic         dst_rst,
    output logic [W-1:0] dst_bin
);
    import wmf_pkg::*;

    logic [W-1:0] gray_q;
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge src_clk) begin
        if (src_rst) gray_q <= '0;
        else         gray_q <= W'(bin_to_gray(32'(src_bin)));
    end

    always_ff @(posedge dst_clk) begin
        if (dst_rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_q;
            sync_q <= meta_q;
        end
    end

    assign dst_bin = W'(gray_to_bin(32'(sync_q)));

endmodule

// File: rtl/wmf_admit.sv
// Slave-side admission: a new burst needs the watermark low; an open burst
// only needs a free slot. Filling the last slot closes the burst.
module wmf_admit (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic last,
    input  logic wm_high,
    input  logic full,
    input  logic fill_next,
    output logic ack,
    output logic tag_last,
    output logic cut,
    output logic busy
);
    import wmf_pkg::*;

    adm_state_t state_q;

    always_comb begin
        ack      = stb && !full && ((state_q == ADM_BURST) || !wm_high);
        tag_last = last || fill_next;
        cut      = ack && fill_next && !last;
        busy     = (state_q == ADM_BURST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ADM_IDLE;
        end else if (ack) begin
            state_q <= tag_last ? ADM_IDLE : ADM_BURST;
        end
    end

endmodule

// File: rtl/wmf_drain.sv
// Read side: opens the next burst only when the synchronized word pointer
// already covers that burst's recorded end, then streams it out.
module wmf_drain #(
    parameter int PW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] wsync,
    input  logic [PW-1:0] tsync,
    input  logic [PW-1:0] end_sel,
    input  logic          word_last,
    input  logic          ready,
    output logic          valid,
    output logic [PW-1:0] ptr,
    output logic [PW-1:0] txn
);
    logic          open_q;
    logic [PW-1:0] ptr_q;
    logic [PW-1:0] txn_q;
    logic [PW-1:0] avail;
    logic [PW-1:0] need;
    logic          start_ok;
    logic          pop;

    always_comb begin
        avail    = wsync - ptr_q;
        need     = end_sel - ptr_q;
        start_ok = (tsync != txn_q) && (avail >= need);
        valid    = open_q || start_ok;
        pop      = valid && ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            ptr_q  <= '0;
            txn_q  <= '0;
        end else if (pop) begin
            ptr_q <= ptr_q + 1'b1;
            if (word_last) begin
                open_q <= 1'b0;
                txn_q  <= txn_q + 1'b1;
            end else begin
                open_q <= 1'b1;
            end
        end
    end

    assign ptr = ptr_q;
    assign txn = txn_q;

endmodule

// File: rtl/wmfifo_burst.sv
module wmfifo_burst #(
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    parameter int WM    = 32
) (
    input  logic          wr_clk,
    input  logic          wr_rst,
    input  logic          s_stb,
    input  logic          s_last,
    input  logic [DW-1:0] s_data,
    output logic          s_ack,
    output logic          s_cut,
    output logic          wm_high,
    input  logic          rd_clk,
    input  logic          rd_rst,
    input  logic          rd_ready,
    output logic          rd_valid,
    output logic          rd_last,
    output logic [DW-1:0] rd_data
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0] WM_P    = PW'(WM);

    // storage: data plus end-of-burst tag, and one end pointer per burst
    logic [DW:0]   mem  [DEPTH];
    logic [PW-1:0] endp [DEPTH];

    // write domain
    logic [PW-1:0] wr_ptr_q, wr_txn_q, rsync, used, free;
    logic          full, fill_next, tag_last, busy;

    // read domain
    logic [PW-1:0] rd_wsync, rd_tsync, rd_ptr, rd_txn;
    logic [DW:0]   rd_word;

    always_comb begin
        used      = wr_ptr_q - rsync;
        free      = DEPTH_P - used;
        full      = (used == DEPTH_P);
        fill_next = (used == DEPTH_P - 1'b1);
        wm_high   = (free < WM_P);
    end

    wmf_admit u_admit (
        .clk      (wr_clk),
        .rst      (wr_rst),
        .stb      (s_stb),
        .last     (s_last),
        .wm_high  (wm_high),
        .full     (full),
        .fill_next(fill_next),
        .ack      (s_ack),
        .tag_last (tag_last),
        .cut      (s_cut),
        .busy     (busy)
    );

    always_ff @(posedge wr_clk) begin
        if (wr_rst) begin
            wr_ptr_q <= '0;
            wr_txn_q <= '0;
        end else if (s_ack) begin
            wr_ptr_q <= wr_ptr_q + 1'b1;
            if (tag_last) wr_txn_q <= wr_txn_q + 1'b1;
        end
    end

    always_ff @(posedge wr_clk) begin
        if (s_ack) begin
            mem[wr_ptr_q[AW-1:0]] <= {tag_last, s_data};
            if (tag_last) endp[wr_txn_q[AW-1:0]] <= wr_ptr_q + 1'b1;
        end
    end

    wmf_gray_cross #(.W(PW)) u_rptr_x (
        .src_clk(rd_clk), .src_rst(rd_rst), .src_bin(rd_ptr),
        .dst_clk(wr_clk), .dst_rst(wr_rst), .dst_bin(rsync)
    );

    wmf_gray_cross #(.W(PW)) u_wptr_x (
        .src_clk(wr_clk), .src_rst(wr_rst), .src_bin(wr_ptr_q),
        .dst_clk(rd_clk), .dst_rst(rd_rst), .dst_bin(rd_wsync)
    );

    wmf_gray_cross #(.W(PW)) u_txn_x (
        .src_clk(wr_clk), .src_rst(wr_rst), .src_bin(wr_txn_q),
        .dst_clk(rd_clk), .dst_rst(rd_rst), .dst_bin(rd_tsync)
    );

    assign rd_word = mem[rd_ptr[AW-1:0]];

    wmf_drain #(.PW(PW)) u_drain (
        .clk      (rd_clk),
        .rst      (rd_rst),
        .wsync    (rd_wsync),
        .tsync    (rd_tsync),
        .end_sel  (endp[rd_txn[AW-1:0]]),
        .word_last(rd_word[DW]),
        .ready    (rd_ready),
        .valid    (rd_valid),
        .ptr      (rd_ptr),
        .txn      (rd_txn)
    );

    assign rd_last = rd_word[DW];
    assign rd_data = rd_word[DW-1:0];

endmodule

// File: rtl/wmf_checker.sv
module wmf_checker #(
    parameter int DW = 32,
    parameter int PW = 7
) (
    input logic          wr_clk,
    input logic          wr_rst,
    input logic          rd_clk,
    input logic          rd_rst,
    input logic          s_stb,
    input logic          s_ack,
    input logic          s_cut,
    input logic          wm_high,
    input logic          full,
    input logic          busy,
    input logic          rd_valid,
    input logic          rd_ready,
    input logic          rd_last,
    input logic [DW-1:0] rd_data,
    input logic [PW-1:0] rd_wsync,
    input logic [PW-1:0] rd_ptr
);
    AST_NO_ACK_WHEN_FULL: assert property (@(posedge wr_clk) disable iff (wr_rst)
        full |-> !s_ack); // R8
    AST_START_NEEDS_ROOM: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (!busy && wm_high) |-> !s_ack); // R5
    AST_BURST_IGNORES_WM: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (busy && s_stb && !full) |-> s_ack); // R6
    AST_CUT_ENDS_BURST: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (s_ack && s_cut) |=> !busy); // R7
    AST_FULL_RAISES_WM: assert property (@(posedge wr_clk) disable iff (wr_rst)
        full |-> wm_high); // R4
    AST_HOLD_WHEN_STALLED: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_last))); // R9
    AST_VALID_HAS_WORD: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_valid |-> (rd_wsync != rd_ptr)); // R3
endmodule

bind wmfifo_burst wmf_checker #(.DW(DW), .PW(PW)) u_chk (
    .wr_clk  (wr_clk),
    .wr_rst  (wr_rst),
    .rd_clk  (rd_clk),
    .rd_rst  (rd_rst),
    .s_stb   (s_stb),
    .s_ack   (s_ack),
    .s_cut   (s_cut),
    .wm_high (wm_high),
    .full    (full),
    .busy    (busy),
    .rd_valid(rd_valid),
    .rd_ready(rd_ready),
    .rd_last (rd_last),
    .rd_data (rd_data),
    .rd_wsync(rd_wsync),
    .rd_ptr  (rd_ptr)
);

// File: tb/wmfifo_burst_tb.sv
`timescale 1ns/1ps
module wmfifo_burst_tb;
    localparam int DW = 32;

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          wr_rst = 1'b1, rd_rst = 1'b1;
    logic          s_stb = 1'b0, s_last = 1'b0;
    logic [DW-1:0] s_data = '0;
    logic          s_ack, s_cut, wm_high;
    logic          rd_ready = 1'b0;
    logic          rd_valid, rd_last;
    logic [DW-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 wr_clk = ~wr_clk;  // 125 MHz
    always #5 rd_clk = ~rd_clk;

    wmfifo_burst #(.DW(DW), .DEPTH(64), .WM(32)) u_dut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .s_stb(s_stb), .s_last(s_last),
        .s_data(s_data), .s_ack(s_ack), .s_cut(s_cut), .wm_high(wm_high),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_ready(rd_ready),
        .rd_valid(rd_valid), .rd_last(rd_last), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // offer one word; returns whether and when it was taken
    task automatic push(input logic [DW-1:0] d, input bit lst, input int max_wait,
                        output bit got, output bit cut, output int waited);
        got = 1'b0; cut = 1'b0; waited = 0;
        @(negedge wr_clk);
        s_stb = 1'b1; s_data = d; s_last = lst;
        for (int i = 0; i < max_wait; i++) begin
            #1;
            if (s_ack) begin
                got = 1'b1; cut = s_cut;
                @(posedge wr_clk); #1;
                return;
            end
            waited++;
            @(negedge wr_clk);
        end
        s_stb = 1'b0;
    endtask

    task automatic wr_idle();
        @(negedge wr_clk);
        s_stb = 1'b0; s_last = 1'b0;
    endtask

    task automatic wait_valid(input int max_cyc, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < max_cyc; i++) begin
            @(negedge rd_clk);
            if (rd_valid) begin seen = 1'b1; return; end
        end
    endtask

    // drain n words expected back-to-back, data base+k, last on index last_at
    task automatic drain(input int n, input logic [DW-1:0] base, input int last_at, input string req);
        bit seen;
        wait_valid(12, seen);
        check(seen, req, seen, 1);
        rd_ready = 1'b1;
        for (int k = 0; k < n; k++) begin
            if (k > 0) @(negedge rd_clk);
            check(rd_valid == 1'b1, "R9 back-to-back valid", rd_valid, 1);
            check(rd_data == base + DW'(k), "R2 data order", rd_data, base + DW'(k));
            check(rd_last == (k == last_at), "R2 last tag", rd_last, (k == last_at));
        end
        @(negedge rd_clk);
        rd_ready = 1'b0;
    endtask

    task automatic wait_wm_low(input string req);
        int i;
        for (i = 0; i < 20; i++) begin
            @(negedge wr_clk);
            if (!wm_high) break;
        end
        check(!wm_high, req, wm_high, 0);
    endtask

    task automatic t_reset();
        repeat (4) @(negedge rd_clk);
        wr_rst = 1'b0; rd_rst = 1'b0;
        @(negedge wr_clk); #1;
        check(wm_high == 1'b0, "R1 wm_high after reset", wm_high, 0);
        check(rd_valid == 1'b0, "R1 rd_valid after reset", rd_valid, 0);
    endtask

    task automatic t_short();
        bit g, c, seen; int w;
        logic [DW-1:0] held;
        for (int k = 0; k < 3; k++) begin
            push(32'd100 + DW'(k), 1'b0, 4, g, c, w);
            if (k == 0) check(g && w == 0, "R1 first word taken at once", w, 0);
        end
        wr_idle();
        repeat (6) @(negedge rd_clk);
        check(rd_valid == 1'b0, "R3 partial burst hidden", rd_valid, 0);
        push(32'd103, 1'b1, 4, g, c, w);
        wr_idle();
        wait_valid(12, seen);
        check(seen, "R3 complete burst released", seen, 1);
        held = rd_data;
        repeat (3) @(negedge rd_clk);
        check(rd_valid && rd_data == held, "R9 held while not ready", rd_data, held);
        drain(4, 32'd100, 3, "R2 short burst");
        repeat (3) @(negedge rd_clk);
        check(rd_valid == 1'b0, "R9 empty after drain", rd_valid, 0);
    endtask

    task automatic t_watermark();
        bit g, c; int w; int late = 0;
        wait_wm_low("R4 watermark clear before fill");
        for (int k = 0; k < 40; k++) begin
            push(32'd1000 + DW'(k), (k == 39), 4, g, c, w);
            if (w != 0 || !g) late++;
            if (k == 31) check(wm_high == 1'b0, "R4 32 words stored", wm_high, 0);
            if (k == 32) check(wm_high == 1'b1, "R4 33 words stored", wm_high, 1);
        end
        wr_idle();
        check(late == 0, "R6 open burst ignores watermark", late, 0);
        push(32'd5000, 1'b1, 12, g, c, w);
        wr_idle();
        check(!g, "R5 new burst refused above watermark", g, 0);
        drain(40, 32'd1000, 39, "R2 forty word burst");
        wait_wm_low("R4 watermark clears after drain");
    endtask

    task automatic t_full_cut();
        bit g, c, cut_seen; int w; int early_cut = 0;
        cut_seen = 1'b0;
        for (int k = 0; k < 64; k++) begin
            push(32'd2000 + DW'(k), 1'b0, 4, g, c, w);
            if (k < 63 && c) early_cut++;
            if (k == 63) cut_seen = g && c;
        end
        check(early_cut == 0, "R7 no cut before last slot", early_cut, 0);
        check(cut_seen, "R7 cut on last free slot", cut_seen, 1);
        push(32'd2064, 1'b0, 10, g, c, w);
        wr_idle();
        check(!g, "R8 no word taken while full", g, 0);
        drain(64, 32'd2000, 63, "R7 cut burst released");
        wait_wm_low("R4 watermark clears after full drain");
        for (int k = 64; k < 70; k++) begin
            push(32'd2000 + DW'(k), (k == 69), 4, g, c, w);
            if (k == 64) check(g && w == 0, "R7 continuation admitted as new burst", w, 0);
        end
        wr_idle();
        drain(6, 32'd2064, 5, "R7 continuation burst");
    endtask

    initial begin
        t_reset();
        t_short();
        t_watermark();
        t_full_cut();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule